// File: doc/BRIEF.md
# 8-bit Timer with Compare Waveform Output

This block is an 8-bit up-counter that produces a single compare waveform. The counter advances on ticks from a prescaler, which divides the system clock by 1, 8, 64, 256 or 1024 or holds the counter still. The count is compared with an 8-bit compare register. Depending on the waveform mode, the counter either wraps freely, clears after a compare match (a frequency generator), or runs single-slope from 0x00 to 0xFF as a fast PWM source whose output polarity can be selected.

A simple write port loads either the compare register or the counter. Two sticky flags, overflow and compare-match, are cleared by writing a one to their bit. In clear-on-match mode a compare write takes effect at once. In fast PWM the write is held in a buffer and only becomes active at the end of the period, so the output cannot glitch. The count, the flags and the waveform bit are all registered outputs.

Top module: `tmr8_wavegen`

## Requirements
- R1: `clk_sel` picks the tick rate: 1 means every clock, 2 means every 8th, 3 every 64th, 4 every 256th and 5 every 1024th. The values 0, 6 and 7 give no ticks, and the count then holds.
- R2: `wave_mode` encoding: 00 is free counting with wrap 0xFF to 0x00, 01 clears on compare match, 10 behaves like 00, and 11 is single-slope fast PWM running 0x00 to 0xFF.
- R3: In mode 01 the counter increments on each tick until it equals the active compare value, then becomes 0x00 on the next tick. With `out_mode` 01, the output toggles on every match, so each output half-period is N·(1+compare) clocks.
- R4: Outside mode 11, a compare write becomes active in the next cycle. If the new value is below the count, no match occurs until the counter has passed 0xFF and wrapped to 0x00.
- R5: `cmp_flag` is set one clock after a tick on which the count equals the active compare value.
- R6: `ovf_flag` is set one clock after a tick on which the count goes from 0xFF to 0x00, in every mode, including a clear-on-match at 0xFF.
- R7: The flags are cleared by writing one: `flag_wc` bit 0 clears `ovf_flag` and bit 1 clears `cmp_flag`. A new set event in the same cycle wins over the clear.
- R8: In mode 11 with `out_mode` 10, the output is high for (compare+1) of every 256 ticks. With `out_mode` 11 it is high for 255−compare ticks. When a match and the wrap fall on the same tick, the wrap action wins.
- R9: In mode 11 a compare write goes into a buffer. The buffer is copied to the active compare on the tick on which the count leaves 0xFF.
- R10: `out_mode` 00 holds the output low, as does 01 in mode 11. Outside mode 11, `out_mode` 10 clears the output on a match and 11 sets it.
- R11: A counter write (`wr_en` with `wr_sel`=1) loads `wr_data` on the next edge, wins over the increment, and suppresses that tick's compare match and overflow.
- R12: After reset the count, the active and buffered compare values, both flags and the output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Prescaler select |
| wave_mode | input | 2 | Waveform mode |
| out_mode | input | 2 | Compare output action |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0: compare register, 1: counter |
| wr_data | input | 8 | Write data |
| flag_wc | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 compare |
| count | output | 8 | Counter value |
| wave_out | output | 1 | Compare waveform |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare-match flag |

## Verification
A tick is decided from the prescaler register in the cycle before an edge. The count, both flags and the waveform bit all change on that edge, and a write shows up one edge after its strobe. The bench drives inputs and samples outputs on falling edges, so every result is read one half-cycle after the edge that produced it.

Periods and duty cycles are measured between output transitions or over a full 256-tick window. This makes them independent of the free-running prescaler's phase. Where an exact cycle matters, such as a counter write colliding with a match, the bench runs the prescaler at divide-by-one, so every edge is a tick.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    WM_FREE = 2'b00,
    WM_CTC  = 2'b01,
    WM_ALT  = 2'b10,
    WM_FPWM = 2'b11
  } wmode_t;

  typedef enum logic [1:0] {
    OM_OFF    = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_CLEAR  = 2'b10,
    OM_SET    = 2'b11
  } omode_t;

  // divider mask: a tick fires when all masked prescaler bits are one
  function automatic logic [9:0] div_mask(input logic [2:0] sel);
    case (sel)
      3'd1:    div_mask = 10'h000;
      3'd2:    div_mask = 10'h007;
      3'd3:    div_mask = 10'h03F;
      3'd4:    div_mask = 10'h0FF;
      default: div_mask = 10'h3FF;
    endcase
  endfunction

  function automatic logic sel_runs(input logic [2:0] sel);
    sel_runs = (sel >= 3'd1) && (sel <= 3'd5);
  endfunction
endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  output logic       tick
);
  import tmr8_pkg::*;

  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  assign mask = PRE_W'(div_mask(sel));
  assign tick = sel_runs(sel) && ((div_q & mask) == mask);
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         ctc,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  input  logic [W-1:0] cmp_act,
  output logic [W-1:0] count,
  output logic         match_ev,
  output logic         wrap_ev
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic adv;
  assign adv      = tick && !ld;
  assign match_ev = adv && (count == cmp_act);
  assign wrap_ev  = adv && (count == MAXV);

  always_ff @(posedge clk) begin
    if (rst)                count <= '0;
    else if (ld)            count <= ld_data;
    else if (tick) begin
      if (ctc && count == cmp_act) count <= '0;
      else                         count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/tmr8_cmpreg.sv
module tmr8_cmpreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwm,
  input  logic         wr,
  input  logic [W-1:0] data,
  input  logic         wrap_ev,
  output logic [W-1:0] cmp_act
);
  logic [W-1:0] cmp_buf;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_buf <= '0;
      cmp_act <= '0;
    end else begin
      if (wr) cmp_buf <= data;
      if (wr && !pwm)          cmp_act <= data;
      else if (pwm && wrap_ev) cmp_act <= cmp_buf;
    end
  end
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwm,
  input  logic [1:0] omode,
  input  logic       match_ev,
  input  logic       wrap_ev,
  output logic       wave
);
  import tmr8_pkg::*;

  omode_t om;
  assign om = omode_t'(omode);

  always_ff @(posedge clk) begin
    if (rst) wave <= 1'b0;
    else if (om == OM_OFF || (pwm && om == OM_TOGGLE)) wave <= 1'b0;
    else if (pwm) begin
      if (wrap_ev)       wave <= (om == OM_CLEAR);
      else if (match_ev) wave <= (om == OM_SET);
    end else if (match_ev) begin
      case (om)
        OM_TOGGLE: wave <= ~wave;
        OM_CLEAR:  wave <= 1'b0;
        default:   wave <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/tmr8_wavegen.sv
module tmr8_wavegen #(
  parameter int W     = 8,
  parameter int PRE_W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   clk_sel,
  input  logic [1:0]   wave_mode,
  input  logic [1:0]   out_mode,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   flag_wc,
  output logic [W-1:0] count,
  output logic         wave_out,
  output logic         ovf_flag,
  output logic         cmp_flag
);
  import tmr8_pkg::*;

  logic         tick, match_ev, wrap_ev, ld_cnt, wr_cmp, pwm, ctc;
  logic [W-1:0] cmp_act;

  assign pwm    = (wmode_t'(wave_mode) == WM_FPWM);
  assign ctc    = (wmode_t'(wave_mode) == WM_CTC);
  assign ld_cnt = wr_en && wr_sel;
  assign wr_cmp = wr_en && !wr_sel;

  tmr8_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .sel(clk_sel), .tick(tick)
  );

  tmr8_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .ctc(ctc), .ld(ld_cnt),
    .ld_data(wr_data), .cmp_act(cmp_act), .count(count),
    .match_ev(match_ev), .wrap_ev(wrap_ev)
  );

  tmr8_cmpreg #(.W(W)) u_cmp (
    .clk(clk), .rst(rst), .pwm(pwm), .wr(wr_cmp), .data(wr_data),
    .wrap_ev(wrap_ev), .cmp_act(cmp_act)
  );

  tmr8_wave u_wave (
    .clk(clk), .rst(rst), .pwm(pwm), .omode(out_mode),
    .match_ev(match_ev), .wrap_ev(wrap_ev), .wave(wave_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (wrap_ev)         ovf_flag <= 1'b1;
      else if (flag_wc[0]) ovf_flag <= 1'b0;
      if (match_ev)        cmp_flag <= 1'b1;
      else if (flag_wc[1]) cmp_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr8_wavegen_chk.sv
module tmr8_wavegen_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic [2:0]   clk_sel,
  input logic [1:0]   wave_mode,
  input logic [1:0]   out_mode,
  input logic         wr_en,
  input logic         wr_sel,
  input logic [W-1:0] wr_data,
  input logic [1:0]   flag_wc,
  input logic [W-1:0] cmp_act,
  input logic [W-1:0] count,
  input logic         wave_out,
  input logic         ovf_flag,
  input logic         cmp_flag
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  // R11
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> (count == $past(wr_data)));

  // R3
  ctc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !(wr_en && wr_sel) && wave_mode == 2'b01 && count == cmp_act) |=> (count == '0));

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !(wr_en && wr_sel) && count == MAXV) |=> ovf_flag);

  // R10
  out_off_chk: assert property (@(posedge clk) disable iff (rst)
    (out_mode == 2'b00) |=> !wave_out);

  // R1
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((clk_sel == 3'd0 || clk_sel > 3'd5) && !(wr_en && wr_sel)) |=> $stable(count));

  // R5
  cmp_from_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_flag) |-> $past(tick));

  // R7
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_wc[0] && !(tick && !(wr_en && wr_sel) && count == MAXV)) |=> !ovf_flag);
endmodule

bind tmr8_wavegen tmr8_wavegen_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .clk_sel(clk_sel), .wave_mode(wave_mode),
  .out_mode(out_mode), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .flag_wc(flag_wc), .cmp_act(cmp_act), .count(count), .wave_out(wave_out),
  .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
);

// File: tb/tmr8_wavegen_bench.sv
module tmr8_wavegen_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] clk_sel = 3'd0;
  logic [1:0] wave_mode = 2'b00;
  logic [1:0] out_mode = 2'b00;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] flag_wc = 2'b00;
  logic [7:0] count;
  logic       wave_out, ovf_flag, cmp_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  tmr8_wavegen u_tmr8_wavegen (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .wave_mode(wave_mode),
    .out_mode(out_mode), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .flag_wc(flag_wc), .count(count), .wave_out(wave_out),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_wc = 2'b11;
    @(negedge clk);
    flag_wc = 2'b00;
  endtask

  task automatic half_period(output int d);
    logic p;
    int t0;
    int n;
    p = wave_out; n = 0;
    while (wave_out == p && n < 5000) begin @(negedge clk); n++; end
    t0 = cyc; p = wave_out; n = 0;
    while (wave_out == p && n < 5000) begin @(negedge clk); n++; end
    d = cyc - t0;
  endtask

  task automatic high_count(output int h);
    h = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (wave_out) h++;
    end
  endtask

  task automatic t_reset();
    chk("R12 count", count, 0);
    chk("R12 wave", wave_out, 0);
    chk("R12 ovf", ovf_flag, 0);
    chk("R12 cmp", cmp_flag, 0);
  endtask

  task automatic t_stopped();
    wave_mode = 2'b00;
    wr(1'b1, 8'h21);
    clk_sel = 3'd0;
    repeat (20) @(negedge clk);
    chk("R1 sel0 holds", count, 8'h21);
    clk_sel = 3'd6;
    repeat (20) @(negedge clk);
    chk("R1 sel6 holds", count, 8'h21);
    clk_sel = 3'd0;
  endtask

  task automatic t_ctc_period(input logic [2:0] sel, input logic [7:0] cv, input int exp);
    int d;
    clk_sel = 3'd0; wave_mode = 2'b01; out_mode = 2'b01;
    wr(1'b0, cv);
    wr(1'b1, 8'h00);
    @(negedge clk); clk_sel = sel;
    half_period(d);
    chk("R3 ctc half period", d, exp);
    half_period(d);
    chk("R3 ctc half period again", d, exp);
    @(negedge clk); clk_sel = 3'd0;
  endtask

  task automatic t_missed_match();
    int n;
    logic [7:0] prev;
    clk_sel = 3'd0; wave_mode = 2'b01; out_mode = 2'b01;
    wr(1'b0, 8'd200);
    wr(1'b1, 8'd100);
    wr(1'b0, 8'd50);
    clear_flags();
    clk_sel = 3'd1;
    n = 0;
    while (count != 8'hFF && n < 400) begin @(negedge clk); n++; end
    chk("R4 count reaches FF", count, 8'hFF);
    chk("R4 no match before wrap", cmp_flag, 0);
    @(negedge clk);
    chk("R4 wrapped to 0", count, 0);
    chk("R6 ovf in CTC", ovf_flag, 1);
    n = 0; prev = count;
    while (!cmp_flag && n < 400) begin prev = count; @(negedge clk); n++; end
    chk("R5 match at new compare", prev, 50);
    chk("R3 cleared after match", count, 0);
    clk_sel = 3'd0;
  endtask

  task automatic t_overflow_w1c();
    clk_sel = 3'd0; wave_mode = 2'b10;
    wr(1'b1, 8'hFD);
    clear_flags();
    clk_sel = 3'd1;
    repeat (3) @(negedge clk);
    clk_sel = 3'd0;
    chk("R2 mode 10 wraps", count, 0);
    chk("R6 ovf set", ovf_flag, 1);
    flag_wc = 2'b10;
    @(negedge clk); flag_wc = 2'b00;
    chk("R7 bit1 leaves ovf", ovf_flag, 1);
    flag_wc = 2'b01;
    @(negedge clk); flag_wc = 2'b00;
    chk("R7 bit0 clears ovf", ovf_flag, 0);
  endtask

  task automatic t_write_priority();
    logic w0;
    clk_sel = 3'd0; wave_mode = 2'b01; out_mode = 2'b01;
    wr(1'b0, 8'h40);
    wr(1'b1, 8'h40);
    clear_flags();
    w0 = wave_out;
    clk_sel = 3'd1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h80;
    @(negedge clk);
    wr_en = 1'b0; clk_sel = 3'd0;
    chk("R11 load wins", count, 8'h80);
    chk("R11 match blocked", cmp_flag, 0);
    chk("R11 wave unchanged", wave_out, w0);
  endtask

  task automatic t_pwm_buffer();
    int n;
    clk_sel = 3'd0; wave_mode = 2'b01; out_mode = 2'b10;
    wr(1'b0, 8'h20);
    wave_mode = 2'b11;
    wr(1'b0, 8'h05);
    wr(1'b1, 8'h10);
    clear_flags();
    clk_sel = 3'd1;
    n = 0;
    while (!cmp_flag && n < 400) begin @(negedge clk); n++; end
    chk("R9 old compare still active", count, 8'h21);
    clear_flags();
    n = 0;
    while (!cmp_flag && n < 400) begin @(negedge clk); n++; end
    chk("R9 buffer active after wrap", count, 8'h06);
    clk_sel = 3'd0;
  endtask

  task automatic t_pwm_duty(input logic [1:0] om, input logic [7:0] cv, input int exp);
    int h;
    clk_sel = 3'd1; wave_mode = 2'b11; out_mode = om;
    wr(1'b0, cv);
    repeat (600) @(negedge clk);
    high_count(h);
    chk("R8 pwm duty", h, exp);
  endtask

  task automatic t_out_modes();
    int h;
    clk_sel = 3'd1; wave_mode = 2'b01;
    wr(1'b0, 8'd3);
    out_mode = 2'b00;
    repeat (10) @(negedge clk);
    high_count(h);
    chk("R10 mode 00 low", h, 0);
    out_mode = 2'b11;
    repeat (20) @(negedge clk);
    chk("R10 set on match", wave_out, 1);
    out_mode = 2'b10;
    repeat (20) @(negedge clk);
    chk("R10 clear on match", wave_out, 0);
    wave_mode = 2'b11; out_mode = 2'b01;
    repeat (10) @(negedge clk);
    high_count(h);
    chk("R10 toggle in pwm low", h, 0);
    clk_sel = 3'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stopped();
    t_ctc_period(3'd1, 8'd3, 4);
    t_ctc_period(3'd1, 8'd0, 1);
    t_ctc_period(3'd2, 8'd2, 24);
    t_ctc_period(3'd3, 8'd0, 64);
    t_ctc_period(3'd4, 8'd1, 512);
    t_ctc_period(3'd5, 8'd0, 1024);
    t_missed_match();
    t_overflow_w1c();
    t_write_priority();
    t_pwm_buffer();
    t_pwm_duty(2'b10, 8'd63, 64);
    t_pwm_duty(2'b11, 8'd63, 192);
    t_pwm_duty(2'b10, 8'hFF, 256);
    t_pwm_duty(2'b11, 8'hFF, 0);
    t_out_modes();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule